// File: doc/BRIEF.md
# Transmit Descriptor Fetch and Stream Engine

This engine walks a chain of transmit descriptors kept in system memory and turns each one into bytes on a MAC-facing byte stream. A descriptor has four 32-bit words, at byte offsets 0, 4, 8 and 12 from its address: a status word whose bit 31 says who owns it, a control word, the address of a data buffer, and the address of the following descriptor. The host fills in descriptors, gives them to hardware by setting the ownership bit, and then strobes a poll request. The engine fetches the descriptor and checks ownership. It streams the buffer, writes a status word with the ownership bit cleared, and moves on along the next pointer.

A frame may span several descriptors. The first-segment and last-segment flags in the control word place the start and end markers on the stream. When the engine meets a descriptor that hardware does not own, it parks on that address and waits for the next poll instead of polling memory again. An underflow report from the MAC side cuts the frame short. The faulted descriptor, and any remaining segments of that frame, are then returned with error status.

Top module: `tdma_tx_engine`

## Requirements
- R1: While reset is asserted, and until the first poll after reset, tx_valid, mem_re, mem_we, tx_done and tx_irq stay low.
- R2: A poll is held pending until both tx_en and tx_start are high. Only then does the engine issue a read of word 0 at the current descriptor address. While either is low, no memory read occurs.
- R3: When bit 31 of word 0 is 0, the engine reads nothing more, writes nothing, and issues no further memory access until the next poll. That poll re-reads the same address.
- R4: For an owned descriptor with length L in control bits 14:0, exactly L bytes are offered. Byte k is bits 8*(k%4)+7:8*(k%4) of the memory word at buffer address + 4*(k/4).
- R5: tx_sof is high on byte 0 of a segment whose control bit 22 is set. tx_eof is high on the last byte of a segment whose control bit 21 is set. tx_nocrc equals control bit 16 on every byte of that segment.
- R6: While tx_valid is high and tx_ready is low (without tx_underrun), the offered byte and its markers stay unchanged into the next cycle.
- R7: After a segment, word 0 of that descriptor is written once, with bit 31 cleared and status 0 on success. tx_done pulses in the same cycle as that write. tx_irq pulses with it only when control bit 23 was set.
- R8: After the write-back, if tx_en and tx_start are still high, the engine reads word 0 at the address taken from word 3, with no new poll needed.
- R9: tx_underrun high while a byte is offered ends the segment at once, and that byte is not taken. The descriptor is written back with status 0x0000_8800 (bit 15 error summary, bit 11 underflow). Every following segment up to and including the one with control bit 21 is written back with the same status and streams no bytes.
- R10: A poll arriving in the same cycle that the engine finds word 0 not owned is not lost: the descriptor is fetched again.
- R11: A segment of length 0 streams no bytes and is still written back with status 0.
- R12: mem_re and mem_we are never high together, and no memory access occurs while a byte is offered. Read data is taken one cycle after mem_re.
- R13: A base_load pulse while the engine is idle sets the current descriptor address to base_addr, and the next poll fetches from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Engine enable level |
| tx_start | input | 1 | Start/run level |
| poll_req | input | 1 | One-cycle poll-demand strobe |
| base_load | input | 1 | Load base_addr as current descriptor address |
| base_addr | input | AW | Descriptor list base address (byte address) |
| mem_re | output | 1 | Memory word read request |
| mem_we | output | 1 | Memory word write request |
| mem_addr | output | AW | Byte address of the accessed word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | MAC accepts the offered byte |
| tx_data | output | 8 | Offered byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_nocrc | output | 1 | Frame must not get a CRC appended |
| tx_underrun | input | 1 | MAC reports output FIFO underflow |
| tx_done | output | 1 | Descriptor written back |
| tx_irq | output | 1 | Completion interrupt request |

## Verification
The main collision is between a host poll and the engine's ownership check. A strobe can land in exactly the cycle in which the engine sees word 0 as not owned and falls back to idle. The bench hits that cycle deliberately: it waits for the word-0 read of a descriptor the host has not yet released, then hands the descriptor over and strobes poll one cycle later. The check is that the frame is still streamed and written back. A second collision is an underflow report that arrives in the same cycle the MAC would have accepted a byte. The bench judges this by requiring that byte to be absent from the stream and the error status to appear on the segment and on its successor.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned IRQ_BIT    = 23;
  localparam int unsigned FIRST_BIT  = 22;
  localparam int unsigned LAST_BIT   = 21;
  localparam int unsigned NOCRC_BIT  = 16;
  localparam int unsigned ERR_BIT    = 15;
  localparam int unsigned UDF_BIT    = 11;
  localparam logic [31:0] STATUS_UDF = (32'd1 << ERR_BIT) | (32'd1 << UDF_BIT);

  typedef enum logic [3:0] {
    S_IDLE, S_W0, S_W1, S_W2, S_W3, S_RDB, S_DAT, S_EMIT, S_WB
  } tdma_state_e;
endpackage

// File: rtl/tdma_poll_ctl.sv
module tdma_poll_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (poll_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/tdma_byte_unpack.sv
module tdma_byte_unpack #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] word_i,
  output logic [7:0]    byte_o
);
  logic [DW-1:0] sh_q, sh_d;
  logic          sh_en;

  assign sh_en = load_i | shift_i;

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = word_i;
    else if (shift_i) sh_d = sh_q >> 8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign byte_o = sh_q[7:0];
endmodule

// File: rtl/tdma_seq.sv
module tdma_seq
  import tdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          pend_i,
  output logic          take_o,
  input  logic          base_load_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          tx_sof_o,
  output logic          tx_eof_o,
  output logic          tx_nocrc_o,
  input  logic          underrun_i,
  output logic          done_o,
  output logic          irq_o,
  output logic          load_o,
  output logic          shift_o
);
  localparam int unsigned WLW  = $clog2(WORD_BYTES) + 1;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  tdma_state_e    state_q, state_d;
  logic [AW-1:0]  cur_q, cur_d, nxt_q, nxt_d, buf_q, buf_d;
  logic [LW-1:0]  rem_q, rem_d;
  logic [WLW-1:0] wleft_q, wleft_d;
  logic first_q, first_d, last_q, last_d, ic_q, ic_d, nocrc_q, nocrc_d;
  logic udf_q, udf_d, drop_q, drop_d, chain_q, chain_d, started_q, started_d;
  logic go;

  assign go = en_i && start_i && (pend_i || chain_q);

  always_comb begin
    state_d = state_q;   cur_d = cur_q;     nxt_d = nxt_q;   buf_d = buf_q;
    rem_d = rem_q;       wleft_d = wleft_q; first_d = first_q;
    last_d = last_q;     ic_d = ic_q;       nocrc_d = nocrc_q;
    udf_d = udf_q;       drop_d = drop_q;   chain_d = chain_q;
    started_d = started_q;
    mem_re_o = 1'b0;  mem_we_o = 1'b0;  mem_addr_o = cur_q;  mem_wdata_o = '0;
    take_o = 1'b0;    tx_valid_o = 1'b0; done_o = 1'b0;  irq_o = 1'b0;
    load_o = 1'b0;    shift_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (base_load_i) begin
          cur_d = base_addr_i;
        end else if (go) begin
          mem_re_o = 1'b1;
          take_o   = 1'b1;
          chain_d  = 1'b0;
          state_d  = S_W0;
        end
      end
      S_W0: begin
        if (mem_rdata_i[OWN_BIT]) begin
          mem_re_o   = 1'b1;
          mem_addr_o = cur_q + STEP;
          state_d    = S_W1;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_W1: begin
        rem_d      = mem_rdata_i[LW-1:0];
        first_d    = mem_rdata_i[FIRST_BIT];
        last_d     = mem_rdata_i[LAST_BIT];
        ic_d       = mem_rdata_i[IRQ_BIT];
        nocrc_d    = mem_rdata_i[NOCRC_BIT];
        mem_re_o   = 1'b1;
        mem_addr_o = cur_q + 2 * STEP;
        state_d    = S_W2;
      end
      S_W2: begin
        buf_d      = mem_rdata_i[AW-1:0];
        mem_re_o   = 1'b1;
        mem_addr_o = cur_q + 3 * STEP;
        state_d    = S_W3;
      end
      S_W3: begin
        nxt_d     = mem_rdata_i[AW-1:0];
        started_d = 1'b0;
        udf_d     = drop_q;
        state_d   = (drop_q || rem_q == '0) ? S_WB : S_RDB;
      end
      S_RDB: begin
        mem_re_o   = 1'b1;
        mem_addr_o = buf_q;
        state_d    = S_DAT;
      end
      S_DAT: begin
        load_o  = 1'b1;
        wleft_d = (rem_q >= LW'(WORD_BYTES)) ? WLW'(WORD_BYTES) : rem_q[WLW-1:0];
        buf_d   = buf_q + STEP;
        state_d = S_EMIT;
      end
      S_EMIT: begin
        tx_valid_o = 1'b1;
        if (underrun_i) begin
          udf_d   = 1'b1;
          drop_d  = !last_q;
          state_d = S_WB;
        end else if (tx_ready_i) begin
          shift_o   = 1'b1;
          rem_d     = rem_q - 1'b1;
          wleft_d   = wleft_q - 1'b1;
          started_d = 1'b1;
          if (rem_q == LW'(1))         state_d = S_WB;
          else if (wleft_q == WLW'(1)) state_d = S_RDB;
        end
      end
      S_WB: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = udf_q ? STATUS_UDF : 32'd0;
        done_o      = 1'b1;
        irq_o       = ic_q;
        cur_d       = nxt_q;
        chain_d     = 1'b1;
        udf_d       = 1'b0;
        if (last_q) drop_d = 1'b0;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign tx_sof_o   = tx_valid_o && first_q && !started_q;
  assign tx_eof_o   = tx_valid_o && last_q && (rem_q == LW'(1));
  assign tx_nocrc_o = tx_valid_o && nocrc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; cur_q <= '0; nxt_q <= '0; buf_q <= '0;
      rem_q <= '0; wleft_q <= '0; first_q <= 1'b0; last_q <= 1'b0;
      ic_q <= 1'b0; nocrc_q <= 1'b0; udf_q <= 1'b0; drop_q <= 1'b0;
      chain_q <= 1'b0; started_q <= 1'b0;
    end else begin
      state_q <= state_d; cur_q <= cur_d; nxt_q <= nxt_d; buf_q <= buf_d;
      rem_q <= rem_d; wleft_q <= wleft_d; first_q <= first_d; last_q <= last_d;
      ic_q <= ic_d; nocrc_q <= nocrc_d; udf_q <= udf_d; drop_q <= drop_d;
      chain_q <= chain_d; started_q <= started_d;
    end
  end
endmodule

// File: rtl/tdma_tx_engine.sv
module tdma_tx_engine #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tx_start,
  input  logic          poll_req,
  input  logic          base_load,
  input  logic [AW-1:0] base_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  output logic          tx_nocrc,
  input  logic          tx_underrun,
  output logic          tx_done,
  output logic          tx_irq
);
  logic [1:0] rsync_q;
  logic       rst_n_int;
  logic       pend, take, load, shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  tdma_poll_ctl i_poll (
    .clk(clk), .rst_n(rst_n_int), .poll_i(poll_req), .take_i(take), .pend_o(pend)
  );

  tdma_byte_unpack #(.DW(32)) i_unpack (
    .clk(clk), .rst_n(rst_n_int), .load_i(load), .shift_i(shift),
    .word_i(mem_rdata), .byte_o(tx_data)
  );

  tdma_seq #(.AW(AW), .LW(LW)) i_seq (
    .clk(clk), .rst_n(rst_n_int), .en_i(tx_en), .start_i(tx_start),
    .pend_i(pend), .take_o(take), .base_load_i(base_load), .base_addr_i(base_addr),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_sof_o(tx_sof),
    .tx_eof_o(tx_eof), .tx_nocrc_o(tx_nocrc), .underrun_i(tx_underrun),
    .done_o(tx_done), .irq_o(tx_irq), .load_o(load), .shift_o(shift)
  );
endmodule

// File: rtl/tdma_tx_engine_chk.sv
module tdma_tx_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_re,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_eof,
  input logic        tx_underrun,
  input logic        tx_done,
  input logic        tx_irq
);
  p_wb_clears_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[31]);

  p_done_is_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> mem_we);

  p_irq_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_done);

  p_status_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == 32'd0 || mem_wdata == 32'h0000_8800));

  p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we, tx_valid}));

  p_hold_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_underrun) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_eof)));
endmodule

bind tdma_tx_engine tdma_tx_engine_chk i_chk (.*);

// File: tb/test_tdma_tx_engine.sv
module test_tdma_tx_engine;
  logic        clk = 1'b0;
  logic        rst_n, tx_en, tx_start, poll_req, base_load;
  logic [31:0] base_addr, mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we, tx_valid, tx_ready, tx_sof, tx_eof, tx_nocrc;
  logic        tx_underrun, tx_done, tx_irq;
  logic [7:0]  tx_data;

  always #10 clk = ~clk;

  tdma_tx_engine i_tdma_tx_engine (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
    .poll_req(poll_req), .base_load(base_load), .base_addr(base_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_nocrc(tx_nocrc), .tx_underrun(tx_underrun), .tx_done(tx_done),
    .tx_irq(tx_irq)
  );

  logic [31:0] mem [256];
  logic        host_we = 1'b0;
  logic [7:0]  host_idx = '0;
  logic [31:0] host_data = '0;

  always @(posedge clk) begin
    if (host_we) mem[host_idx] <= host_data;
    if (mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_re)  mem_rdata <= mem[mem_addr[9:2]];
  end

  int checks = 0, errors = 0, acc_cnt = 0, rd_cnt = 0;
  logic [31:0] last_rd = '0;
  logic        run = 1'b0;
  logic [10:0] byte_q[$];
  logic [64:0] wr_q[$];
  logic [7:0]  lfsr = 8'hA5;
  logic        hold_prev = 1'b0;
  logic [9:0]  prev_byte = '0;

  function automatic void chk(bit ok, string req, logic [64:0] got, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endfunction

  function automatic logic [7:0] bval(int a);
    return 8'((a * 29 + 11) ^ (a >> 4));
  endfunction

  function automatic logic [31:0] ctl(bit ic, bit first, bit last, bit nocrc, int len);
    return {8'b0, ic, first, last, 4'b0, nocrc, 1'b0, 15'(len)};
  endfunction

  // random backpressure
  always @(negedge clk) begin
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = lfsr[0] | lfsr[2];
  end

  // reference comparison, away from the edges
  always @(negedge clk) begin
    #5;
    if (run) begin
      if (hold_prev)
        chk(tx_valid && {tx_eof, tx_sof, tx_data} == prev_byte, "R6",
            65'({tx_valid, tx_eof, tx_sof, tx_data}), 65'({1'b1, prev_byte}));
      hold_prev = tx_valid && !tx_ready && !tx_underrun;
      prev_byte = {tx_eof, tx_sof, tx_data};
      if (mem_re) begin rd_cnt++; last_rd = mem_addr; end
      if ((mem_re && mem_we) || (tx_valid && (mem_re || mem_we)))
        chk(0, "R12", 65'({mem_re, mem_we, tx_valid}), 65'(0));
      if (tx_valid && tx_ready && !tx_underrun) begin
        acc_cnt++;
        if (byte_q.size() == 0) chk(0, "R4 unexpected byte", 65'(tx_data), 65'(0));
        else begin
          logic [10:0] e;
          e = byte_q.pop_front();
          chk({tx_nocrc, tx_sof, tx_eof, tx_data} == e, "R4 R5",
              65'({tx_nocrc, tx_sof, tx_eof, tx_data}), 65'(e));
        end
      end
      if (mem_we) begin
        if (wr_q.size() == 0) chk(0, "R7 unexpected write", 65'({mem_addr, mem_wdata}), 65'(0));
        else begin
          logic [64:0] w;
          w = wr_q.pop_front();
          chk({mem_addr, mem_wdata, tx_irq} == w && tx_done, "R7 R9 R11",
              {mem_addr, mem_wdata, tx_irq}, w);
        end
      end else if (tx_done || tx_irq) chk(0, "R7 done without write", 65'({tx_done, tx_irq}), 65'(0));
    end
  end

  task automatic host_wr(input int addr, input logic [31:0] d);
    host_we = 1'b1; host_idx = 8'(addr >> 2); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic put_desc(input int d, input bit own, input logic [31:0] c,
                          input int bufa, input int nxt);
    host_wr(d + 4, c);
    host_wr(d + 8, 32'(bufa));
    host_wr(d + 12, 32'(nxt));
    host_wr(d, {own, 31'b0});
  endtask

  task automatic expect_seg(input int d, input logic [31:0] c, input int bufa,
                            input int limit, input bit bad);
    int len, n;
    len = int'(c[14:0]);
    n = (limit < len) ? limit : len;
    for (int k = 0; k < n; k++)
      byte_q.push_back({c[16], c[22] && k == 0, c[21] && k == len - 1, bval(bufa + k)});
    wr_q.push_back({32'(d), bad ? 32'h0000_8800 : 32'h0, c[23]});
  endtask

  task automatic poll();
    poll_req = 1'b1; @(negedge clk); poll_req = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((byte_q.size() != 0 || wr_q.size() != 0) && t < 3000) begin
      @(negedge clk); t++;
    end
    if (t >= 3000) chk(0, "watchdog drain", 65'(byte_q.size()), 65'(0));
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    chk(0, "watchdog global", 65'(0), 65'(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    rst_n = 1'b0; tx_en = 1'b0; tx_start = 1'b0; poll_req = 1'b0;
    base_load = 1'b0; base_addr = '0; tx_underrun = 1'b0;
    for (int i = 0; i < 256; i++)
      host_wr(i * 4, (i >= 64) ? {bval(4*i+3), bval(4*i+2), bval(4*i+1), bval(4*i)} : 32'h0);
    chk(!tx_valid && !mem_re && !mem_we && !tx_done && !tx_irq, "R1 in reset",
        65'({tx_valid, mem_re, mem_we, tx_done, tx_irq}), 65'(0));
    rst_n = 1'b1;
    run = 1'b1;
    repeat (6) @(negedge clk);
    chk(rd_cnt == 0 && !tx_valid && !mem_we && !tx_done, "R1 after reset",
        65'(rd_cnt), 65'(0));
    tx_en = 1'b1; tx_start = 1'b1;

    // single segment, interrupt requested
    put_desc('h40, 1, ctl(1, 1, 1, 0, 7), 'h100, 'h50);
    base_addr = 'h40; base_load = 1'b1; @(negedge clk); base_load = 1'b0;
    expect_seg('h40, ctl(1, 1, 1, 0, 7), 'h100, 99, 0);
    poll();
    drain();
    chk(last_rd == 32'h50, "R8 follow next", 65'(last_rd), 65'(32'h50));
    r = rd_cnt;
    repeat (30) @(negedge clk);
    chk(rd_cnt == r, "R3 parked", 65'(rd_cnt), 65'(r));

    // two segments, no-CRC on the first, interrupt on the last
    put_desc('h60, 1, ctl(1, 0, 1, 0, 6), 'h180, 'h70);
    put_desc('h50, 1, ctl(0, 1, 0, 1, 5), 'h140, 'h60);
    expect_seg('h50, ctl(0, 1, 0, 1, 5), 'h140, 99, 0);
    expect_seg('h60, ctl(1, 0, 1, 0, 6), 'h180, 99, 0);
    poll();
    chk(last_rd == 32'h50, "R3 re-read same address", 65'(last_rd), 65'(32'h50));
    drain();
    chk(last_rd == 32'h70, "R8 chain", 65'(last_rd), 65'(32'h70));

    // zero length segment
    put_desc('h70, 1, ctl(0, 1, 1, 0, 0), 0, 'h80);
    expect_seg('h70, ctl(0, 1, 1, 0, 0), 0, 99, 0);
    poll();
    drain();

    // underflow after three bytes of a two-segment frame
    put_desc('h90, 1, ctl(1, 0, 1, 0, 4), 'h200, 'hA0);
    put_desc('h80, 1, ctl(0, 1, 0, 0, 10), 'h1C0, 'h90);
    expect_seg('h80, ctl(0, 1, 0, 0, 10), 'h1C0, 3, 1);
    expect_seg('h90, ctl(1, 0, 1, 0, 4), 'h200, 0, 1);
    r = acc_cnt;
    poll();
    while (!(acc_cnt == r + 3 && tx_valid)) @(negedge clk);
    tx_underrun = 1'b1; @(negedge clk); tx_underrun = 1'b0;
    drain();
    chk(acc_cnt == r + 3, "R9 truncated", 65'(acc_cnt - r), 65'(3));

    // poll while disabled is held
    tx_en = 1'b0;
    put_desc('hA0, 1, ctl(0, 1, 1, 0, 2), 'h240, 'hB0);
    expect_seg('hA0, ctl(0, 1, 1, 0, 2), 'h240, 99, 0);
    r = rd_cnt;
    poll();
    repeat (30) @(negedge clk);
    chk(rd_cnt == r, "R2 no read while disabled", 65'(rd_cnt), 65'(r));
    chk(byte_q.size() == 2, "R2 nothing streamed", 65'(byte_q.size()), 65'(2));
    tx_en = 1'b1;
    drain();

    // poll coincides with the not-owned check (R10)
    put_desc('hB0, 0, ctl(1, 1, 1, 0, 4), 'h280, 'hC0);
    expect_seg('hB0, ctl(1, 1, 1, 0, 4), 'h280, 99, 0);
    poll();
    chk(mem_re && mem_addr == 32'hB0, "R2 fetch word0", 65'({mem_re, mem_addr}), 65'({1'b1, 32'hB0}));
    poll_req = 1'b1; host_we = 1'b1; host_idx = 8'('hB0 >> 2); host_data = 32'h8000_0000;
    @(negedge clk);
    poll_req = 1'b0; host_we = 1'b0;
    drain();
    chk(wr_q.size() == 0, "R10 refetch", 65'(wr_q.size()), 65'(0));

    // new base address
    put_desc('h10, 1, ctl(1, 1, 1, 1, 3), 'h2C0, 'h00);
    base_addr = 'h10; base_load = 1'b1; @(negedge clk); base_load = 1'b0;
    expect_seg('h10, ctl(1, 1, 1, 1, 3), 'h2C0, 99, 0);
    poll();
    drain();
    chk(last_rd == 32'h0, "R13 base then next", 65'(last_rd), 65'(0));

    run = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule